// File: doc/BRIEF.md
# MDIO Management Command Controller

This block is a register-driven MDIO master. Software uses it to run one clause-22 management transaction at a time against an external PHY. A 32-bit register-bus slave exposes two registers: a command word and a data word. For a write, software first loads the data word. It then writes the command word with the PHY address, register address, direction and MDC divider select, and sets the busy bit.

The block runs one full 64-bit frame on MDC/MDIO. On a read it captures the PHY's 16-bit reply into the data word. When the frame ends it clears busy. Software polls busy to learn when the transaction is complete. The MDIO pin is split into a driven value, an output enable and a sampled input, so an external pad cell can implement the tri-state behaviour.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset the command word and the data word both read 0, `mdc_o` is low and `mdio_oe_o` is low.
- R2: The command word is at byte offset 0x0 and the data word at offset 0x4. Command fields: bit 0 busy, bit 1 write (1 = write, 0 = read), bits 8:4 PHY register address, bits 16:12 PHY address, bits 21:20 divider select. All other command bits read 0. The data word keeps bits 15:0 and reads 0 above them. Any other offset reads 0.
- R3: Writing the command word with bit 0 set while idle starts one frame. Busy reads 1 from the next cycle until the frame's last MDC cycle has finished, then reads 0. While busy is 0, MDC stays low and MDIO is not driven.
- R4: Each frame is exactly 64 MDC cycles, sent MSB first, with MDIO changing only while MDC is low. The bit order is: 32 ones, start 01, opcode (10 read, 01 write), the 5-bit PHY address, the 5-bit register address, a 2-bit turnaround, then 16 data bits.
- R5: A write frame drives the turnaround as 10, followed by the data word value that was held when the command was issued.
- R6: A read frame drives MDIO only for its first 46 bits and releases it for the turnaround and data bits. It samples `mdio_i` on each rising MDC edge of the data bits and places the 16-bit result in data word bits 15:0 when busy clears.
- R7: The MDC period is 16, 32, 64 or 128 core clocks for divider select 0, 1, 2 or 3.
- R8: A command write while busy is 1 is ignored: the stored command fields are unchanged and no extra frame follows.
- R9: A data write while busy is 1 is ignored: the data word and the frame's data bits keep the earlier value.
- R10: Writing the command word with bit 0 clear stores the fields but starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Access is a write |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| mdc_o | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Value driven onto MDIO |
| mdio_oe_o | output | 1 | MDIO driver enable |
| mdio_i | input | 1 | Sampled MDIO pin level |

## Verification
The bench uses the default parameters: a 4-bit address, which is enough to reach both registers and one unused offset, and a base divide of 16. With these defaults, all four divider selects fit inside a short run, so the MDC period can be measured for every select. Eight-cycle half periods leave room to issue register writes in the middle of a frame. This is what lets the bench test that writes made while busy are ignored. A bus-functional PHY in the bench records every driven bit and enable on the rising edges of MDC, and returns a chosen reply during read data bits.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam int TA_POS    = 46;
  localparam int DATA_POS  = 48;
  localparam int PHY_W     = 5;
  localparam int REG_W     = 5;
  localparam int DATA_W    = 16;
  localparam int SEL_W     = 2;
  localparam int NSEL      = 1 << SEL_W;

  localparam int B_BUSY = 0;
  localparam int B_WR   = 1;
  localparam int B_REG  = 4;
  localparam int B_PHY  = 12;
  localparam int B_DIV  = 20;

  typedef struct packed {
    logic [SEL_W-1:0] div;
    logic [PHY_W-1:0] phy;
    logic [REG_W-1:0] regad;
    logic             wr;
  } cmd_t;

  function automatic logic [31:0] cmd_pack(cmd_t c, logic busy);
    logic [31:0] w;
    w = '0;
    w[B_BUSY]           = busy;
    w[B_WR]             = c.wr;
    w[B_REG +: REG_W]   = c.regad;
    w[B_PHY +: PHY_W]   = c.phy;
    w[B_DIV +: SEL_W]   = c.div;
    return w;
  endfunction

  function automatic cmd_t cmd_unpack(logic [31:0] w);
    cmd_t c;
    c.wr    = w[B_WR];
    c.regad = w[B_REG +: REG_W];
    c.phy   = w[B_PHY +: PHY_W];
    c.div   = w[B_DIV +: SEL_W];
    return c;
  endfunction
endpackage

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic                done_i,
  input  logic [DATA_W-1:0]   rd_data_i,
  output logic                busy_o,
  output logic                start_o,
  output cmd_t                cmd_o,
  output logic [DATA_W-1:0]   data_o
);
  localparam int WSEL = ADDR_W - 2;

  logic            sel_cmd, sel_data;
  cmd_t            cmd_q;
  logic            busy_q, start_q;
  logic [DATA_W-1:0] data_q;

  assign sel_cmd  = (addr_i[ADDR_W-1:2] == WSEL'(0));
  assign sel_data = (addr_i[ADDR_W-1:2] == WSEL'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      data_q  <= '0;
    end else begin
      start_q <= 1'b0;
      if (done_i) begin
        busy_q <= 1'b0;
        if (!cmd_q.wr) data_q <= rd_data_i;
      end
      // writes are dropped for the whole transaction
      if (req_i && we_i && !busy_q) begin
        if (sel_cmd) begin
          cmd_q   <= cmd_unpack(wdata_i);
          busy_q  <= wdata_i[B_BUSY];
          start_q <= wdata_i[B_BUSY];
        end else if (sel_data) begin
          data_q  <= wdata_i[DATA_W-1:0];
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_cmd)       rdata_o = cmd_pack(cmd_q, busy_q);
    else if (sel_data) rdata_o = {{(32-DATA_W){1'b0}}, data_q};
  end

  assign busy_o  = busy_q;
  assign start_o = start_q;
  assign cmd_o   = cmd_q;
  assign data_o  = data_q;
endmodule

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv
  import mdio_pkg::*;
#(
  parameter int MIN_DIV = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int MIN_HALF = MIN_DIV / 2;
  localparam int MAX_HALF = MIN_HALF * (1 << (NSEL - 1));
  localparam int CNT_W    = $clog2(MAX_HALF);

  logic [CNT_W-1:0] lim [NSEL];
  logic [CNT_W-1:0] cnt_q;

  for (genvar g = 0; g < NSEL; g++) begin : g_lim
    assign lim[g] = CNT_W'(MIN_HALF * (1 << g) - 1);
  end

  assign tick_o = run_i && (cnt_q == lim[sel_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  cmd_t              cmd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tick_i,
  input  logic              mdio_i,
  output logic              run_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int BC_W = $clog2(FRAME_LEN);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(FRAME_LEN - 1);
  localparam logic [BC_W-1:0] TA_BIT   = BC_W'(TA_POS);
  localparam logic [BC_W-1:0] DATA_BIT = BC_W'(DATA_POS);

  logic                 run_q, mdc_q, wr_q, done_q;
  logic [BC_W-1:0]      bit_q;
  logic [FRAME_LEN-1:0] sh_q;
  logic [DATA_W-1:0]    rd_q;
  logic [FRAME_LEN-1:0] frame;

  assign frame = {32'hFFFF_FFFF, 2'b01,
                  cmd_i.wr ? 2'b01 : 2'b10,
                  cmd_i.phy, cmd_i.regad,
                  cmd_i.wr ? 2'b10 : 2'b11,
                  cmd_i.wr ? wdata_i : {DATA_W{1'b1}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      mdc_q  <= 1'b0;
      wr_q   <= 1'b0;
      done_q <= 1'b0;
      bit_q  <= '0;
      sh_q   <= '0;
      rd_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !run_q) begin
        run_q <= 1'b1;
        mdc_q <= 1'b0;
        wr_q  <= cmd_i.wr;
        bit_q <= '0;
        sh_q  <= frame;
      end else if (tick_i) begin
        if (!mdc_q) begin
          mdc_q <= 1'b1;
          if (bit_q >= DATA_BIT) rd_q <= {rd_q[DATA_W-2:0], mdio_i};
        end else begin
          mdc_q <= 1'b0;
          if (bit_q == LAST_BIT) begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
            sh_q   <= '0;
          end else begin
            bit_q <= bit_q + 1'b1;
            sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign run_o     = run_q;
  assign mdc_o     = mdc_q;
  assign mdio_o    = sh_q[FRAME_LEN-1];
  assign mdio_oe_o = run_q && (wr_q || (bit_q < TA_BIT));
  assign done_o    = done_q;
  assign rdata_o   = rd_q;
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int MIN_DIV = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  logic              busy, start, done, run, tick;
  cmd_t              cmd;
  logic [DATA_W-1:0] data_word, rd_data;
  logic [31:0]       cmd_word;
  logic              wr_cmd, wr_data;

  assign cmd_word = cmd_pack(cmd, busy);
  assign wr_cmd   = bus_req_i && bus_we_i && (bus_addr_i[ADDR_W-1:2] == (ADDR_W-2)'(0));
  assign wr_data  = bus_req_i && bus_we_i && (bus_addr_i[ADDR_W-1:2] == (ADDR_W-2)'(1));

  mdio_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (bus_req_i),
    .we_i      (bus_we_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .rdata_o   (bus_rdata_o),
    .done_i    (done),
    .rd_data_i (rd_data),
    .busy_o    (busy),
    .start_o   (start),
    .cmd_o     (cmd),
    .data_o    (data_word)
  );

  mdio_clkdiv #(.MIN_DIV(MIN_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .sel_i  (cmd.div),
    .tick_o (tick)
  );

  mdio_frame u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .cmd_i     (cmd),
    .wdata_i   (data_word),
    .tick_i    (tick),
    .mdio_i    (mdio_i),
    .run_o     (run),
    .mdc_o     (mdc_o),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .done_o    (done),
    .rdata_o   (rd_data)
  );
endmodule

// File: rtl/mdio_cmd_ctrl_chk.sv
module mdio_cmd_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_i,
  input logic        done_i,
  input logic [31:0] cmd_i,
  input logic [15:0] data_i,
  input logic        wr_cmd_i,
  input logic        wr_data_i,
  input logic        mdc_i,
  input logic        mdio_i,
  input logic        oe_i
);
  assert_idle_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!mdc_i && !oe_i));

  assert_busy_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> $past(done_i));

  assert_mdio_low_phase_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mdio_i) |-> !mdc_i);

  assert_oe_low_phase_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_i) |-> !mdc_i);

  assert_cmd_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && wr_cmd_i) |=> (cmd_i[31:1] == $past(cmd_i[31:1])));

  assert_data_locked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && wr_data_i && !done_i) |=> (data_i == $past(data_i)));
endmodule

bind mdio_cmd_ctrl mdio_cmd_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_i    (busy),
  .done_i    (done),
  .cmd_i     (cmd_word),
  .data_i    (data_word),
  .wr_cmd_i  (wr_cmd),
  .wr_data_i (wr_data),
  .mdc_i     (mdc_o),
  .mdio_i    (mdio_o),
  .oe_i      (mdio_oe_o)
);

// File: tb/mdio_cmd_ctrl_tb.sv
module mdio_cmd_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int AW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic mdc, mdo, moe, mdi = 1'b1;

  int checks = 0, errors = 0;
  int rcnt = 0;
  longint cyc = 0;
  longint rise_t [2];
  logic [63:0] cap_d, cap_oe;
  logic [15:0] phy_rd = '0;

  always #(CLK_P/2) clk = ~clk;

  mdio_cmd_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .mdc_o(mdc), .mdio_o(mdo), .mdio_oe_o(moe), .mdio_i(mdi)
  );

  always @(posedge clk) cyc++;

  always @(posedge mdc) begin
    if (rcnt < 64) begin
      cap_d[63-rcnt]  = mdo;
      cap_oe[63-rcnt] = moe;
    end
    if (rcnt < 2) rise_t[rcnt] = cyc;
    rcnt++;
  end

  always @(negedge mdc) begin
    if (rcnt >= 48 && rcnt < 64) mdi = phy_rd[63-rcnt];
    else mdi = 1'b1;
  end

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [31:0] mk_cmd(logic go, logic wr, logic [4:0] phy, logic [4:0] rg, logic [1:0] sel);
    return (32'(sel) << 20) | (32'(phy) << 12) | (32'(rg) << 4) | (32'(wr) << 1) | 32'(go);
  endfunction

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 20000; i++) begin
      bus_read(4'h0, d);
      if (!d[0]) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(4'h0, d); check(d == 0, "R1 cmd reset", 64'(d), 0);
    bus_read(4'h4, d); check(d == 0, "R1 data reset", 64'(d), 0);
    check(!mdc && !moe, "R1 pins reset", {62'b0, mdc, moe}, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    rcnt = 0;
    bus_write(4'h0, 32'hFFFF_FFFE);
    bus_read(4'h0, d); check(d == 32'h0031_F1F2, "R2 R10 cmd fields", 64'(d), 64'h0031_F1F2);
    repeat (100) @(negedge clk);
    check(rcnt == 0 && !mdc, "R10 no frame", 64'(rcnt), 0);
    bus_write(4'h4, 32'hABCD_1234);
    bus_read(4'h4, d); check(d == 32'h0000_1234, "R2 data width", 64'(d), 64'h1234);
    bus_read(4'h8, d); check(d == 0, "R2 unused offset", 64'(d), 0);
  endtask

  task automatic t_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] val, input logic [1:0] sel);
    logic [31:0] d;
    logic [63:0] exp;
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rg, 2'b10, val};
    bus_write(4'h4, {16'h0, val});
    rcnt = 0;
    bus_write(4'h0, mk_cmd(1'b1, 1'b1, phy, rg, sel));
    bus_read(4'h0, d); check(d[0] == 1'b1, "R3 busy set", 64'(d), 1);
    wait_idle();
    bus_read(4'h0, d); check(d == mk_cmd(1'b0, 1'b1, phy, rg, sel), "R3 busy cleared", 64'(d), 64'(mk_cmd(1'b0, 1'b1, phy, rg, sel)));
    check(rcnt == 64, "R4 frame length", 64'(rcnt), 64);
    check(cap_d == exp, "R4 R5 write frame", cap_d, exp);
    check(cap_oe == '1, "R5 write drive", cap_oe, '1);
    check(rise_t[1] - rise_t[0] == longint'(16 << sel), "R7 mdc period", 64'(rise_t[1] - rise_t[0]), 64'(16 << sel));
  endtask

  task automatic t_read(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] val, input logic [1:0] sel);
    logic [31:0] d;
    logic [63:0] exp;
    exp = {32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg, 18'h0};
    phy_rd = val;
    mdi = 1'b1;
    rcnt = 0;
    bus_write(4'h0, mk_cmd(1'b1, 1'b0, phy, rg, sel));
    wait_idle();
    check(rcnt == 64, "R4 read frame length", 64'(rcnt), 64);
    check(cap_d[63:18] == exp[63:18], "R4 read header", 64'(cap_d[63:18]), 64'(exp[63:18]));
    check(cap_oe == {{46{1'b1}}, 18'h0}, "R6 release", cap_oe, {{46{1'b1}}, 18'h0});
    bus_read(4'h4, d); check(d == {16'h0, val}, "R6 read data", 64'(d), 64'(val));
    check(rise_t[1] - rise_t[0] == longint'(16 << sel), "R7 read mdc period", 64'(rise_t[1] - rise_t[0]), 64'(16 << sel));
  endtask

  task automatic t_busy_ignore();
    logic [31:0] d, c0;
    c0 = mk_cmd(1'b1, 1'b1, 5'd3, 5'd7, 2'd0);
    bus_write(4'h4, 32'h5A5A);
    rcnt = 0;
    bus_write(4'h0, c0);
    repeat (40) @(negedge clk);
    bus_write(4'h0, mk_cmd(1'b1, 1'b0, 5'd9, 5'd2, 2'd3));
    bus_write(4'h4, 32'h1111);
    bus_read(4'h0, d); check(d == c0, "R8 cmd locked", 64'(d), 64'(c0));
    bus_read(4'h4, d); check(d == 32'h5A5A, "R9 data locked", 64'(d), 64'h5A5A);
    wait_idle();
    repeat (300) @(negedge clk);
    check(rcnt == 64, "R8 single frame", 64'(rcnt), 64);
    check(cap_d[15:0] == 16'h5A5A, "R9 frame data kept", 64'(cap_d[15:0]), 64'h5A5A);
    bus_read(4'h0, d); check(d == (c0 & ~32'h1), "R8 cmd after", 64'(d), 64'(c0 & ~32'h1));
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_regmap();
    t_write(5'h01, 5'h00, 16'h1340, 2'd0);
    t_write(5'h1E, 5'h15, 16'hA5C3, 2'd1);
    t_write(5'h11, 5'h0A, 16'h8001, 2'd2);
    t_write(5'h00, 5'h1F, 16'hFFFF, 2'd3);
    t_read(5'h02, 5'h03, 16'hC0DE, 2'd0);
    t_read(5'h1F, 5'h1F, 16'h0001, 2'd1);
    t_read(5'h05, 5'h10, 16'h8000, 2'd2);
    t_busy_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule